// File: doc/BRIEF.md
# Reset Cause Status Tracker

This block holds seven sticky status flags that firmware reads after a restart or a wake-up to learn what caused it. Single-cycle event pulses arrive for power-on, brown-out, the software reset instruction, external master-clear, watchdog time-out, stack full, stack underflow and interrupt wake. Each event changes its own subset of flags: some are set, some are cleared and the rest are kept. The change can depend on the current power mode. Only one event is applied per cycle, chosen by a fixed priority.

For each applied event the block also says whether the core restarts or resumes. A true reset pulses `restart_o` and sets `next_pc_o` to the reset vector. A wake-up pulses `wake_o` and sets `next_pc_o` either to the current program counter plus one instruction or to an interrupt vector. Firmware can re-arm the flags through a write port. A hardware event in the same cycle overrides the write, but only for the flags that the event touches.

Top module: `rst_cause_tracker`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `flags_o` is 7'b0000111, `restart_o` and `wake_o` are 0, and `next_pc_o` is 0. Flag bit positions: [0] inst_n, [1] wdt_n, [2] pdn_n, [3] pon_n, [4] brn_n, [5] stk_ovf, [6] stk_udf. Every flag update and every output appears one cycle after the event pulse.
- R2: Power-on sets inst_n, wdt_n and pdn_n to 1. It clears pon_n, stk_ovf and stk_udf to 0. It sets brn_n to 1 only when `bor_cfg_i`==2'b01 and `bor_sw_en_i`==1, and to 0 otherwise. It pulses `restart_o` and loads `next_pc_o` with 0.
- R3: Brown-out sets inst_n, wdt_n and pdn_n to 1 and clears brn_n to 0. It keeps pon_n, stk_ovf and stk_udf. It restarts at 0.
- R4: The reset instruction clears inst_n and keeps every other flag. It restarts at 0.
- R5: Master-clear always restarts at 0. The power mode `pmode_i` is encoded as 0 full power, 1 run, 2 idle, 3 sleep. In mode 0 master-clear changes no flag. In mode 1 it sets wdt_n to 1. In modes 2 and 3 it sets wdt_n to 1 and clears pdn_n.
- R6: In modes 0 and 1 a watchdog time-out clears wdt_n and restarts at 0. In modes 2 and 3 it clears wdt_n and pdn_n, pulses `wake_o` instead of `restart_o`, and loads `next_pc_o` with `cur_pc_i`+2.
- R7: When `stk_rst_en_i` is 1, a stack-full pulse sets stk_ovf, a stack-underflow pulse sets stk_udf, and either one restarts at 0. When `stk_rst_en_i` is 0, stack-full has no effect. In that case underflow still sets stk_udf, but there is no restart and no wake, and `next_pc_o` is kept.
- R8: An interrupt wake clears pdn_n and pulses `wake_o`. The next PC is 0x008 when `gie_hi_i` is 1. Otherwise it is 0x018 when `gie_lo_i` is 1. Otherwise it is `cur_pc_i`+2.
- R9: When several events pulse in one cycle, only the highest one is applied: power-on, then brown-out, then master-clear, then watchdog, then stack, then the reset instruction, then interrupt wake.
- R10: A write with `sw_we_i` loads `sw_wdata_i` into the flags, visible one cycle later. Flags touched by an event applied in the same cycle take the event's value instead.
- R11: `restart_o` and `wake_o` are never high together. Each is a single-cycle pulse. With no event and no write, the flags and `next_pc_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| por_i | input | 1 | Power-on event pulse |
| bor_i | input | 1 | Brown-out event pulse |
| swrst_i | input | 1 | Reset-instruction event pulse |
| mclr_i | input | 1 | Master-clear event pulse |
| wdt_i | input | 1 | Watchdog time-out pulse |
| stk_full_i | input | 1 | Stack-full pulse |
| stk_unf_i | input | 1 | Stack-underflow pulse |
| irq_wake_i | input | 1 | Interrupt wake pulse |
| pmode_i | input | 2 | Power mode (0 full, 1 run, 2 idle, 3 sleep) |
| stk_rst_en_i | input | 1 | Stack errors cause a reset |
| gie_hi_i | input | 1 | High-priority global interrupt enable |
| gie_lo_i | input | 1 | Low-priority global interrupt enable |
| bor_cfg_i | input | 2 | Brown-out configuration field |
| bor_sw_en_i | input | 1 | Software brown-out enable |
| cur_pc_i | input | PC_W | Program counter of the current instruction |
| sw_we_i | input | 1 | Flag write strobe |
| sw_wdata_i | input | 7 | Flag write data |
| flags_o | output | 7 | Sticky status flags |
| restart_o | output | 1 | Restart pulse |
| wake_o | output | 1 | Resume pulse |
| next_pc_o | output | PC_W | PC at which execution continues |

## Verification
The assertions assume that every event input is sampled only when `rst_ni` is high. They also assume that `pmode_i`, the interrupt enables and `stk_rst_en_i` are stable for the cycle in which an event is sampled. Some properties need an event with nothing of higher priority pending, so those properties test that condition in their antecedents instead of assuming it. The stimulus drives every input at the falling edge and never pulses an event while reset is asserted. The random phase keeps each event's probability low, so that isolated events occur often, and directed steps supply the collisions, the mode sweeps and the same-cycle write overrides.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int NFLAG = 7;
  localparam int NREQ  = 7;

  localparam int F_INST = 0;
  localparam int F_WDT  = 1;
  localparam int F_PDN  = 2;
  localparam int F_PON  = 3;
  localparam int F_BRN  = 4;
  localparam int F_OVF  = 5;
  localparam int F_UDF  = 6;

  localparam logic [NFLAG-1:0] RST_FLAGS = 7'b0000111;

  typedef enum logic [2:0] {
    EV_NONE, EV_PON, EV_BRN, EV_MCLR, EV_WDT, EV_STK, EV_INST, EV_IRQ
  } ev_e;

  typedef enum logic [1:0] {
    PM_FULL = 2'd0, PM_RUN = 2'd1, PM_IDLE = 2'd2, PM_SLEEP = 2'd3
  } pmode_e;

  typedef enum logic [2:0] {
    PC_HOLD, PC_RST, PC_NEXT, PC_HI, PC_LO
  } pc_sel_e;

  typedef struct packed {
    logic [NFLAG-1:0] mask;
    logic [NFLAG-1:0] val;
    logic             restart;
    logic             wake;
    pc_sel_e          pc_sel;
  } upd_t;
endpackage

// File: rtl/rst_cause_arb.sv
module rst_cause_arb #(
  parameter int N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // bit 0 is the highest priority
  logic [N-1:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign gnt_o[i] = req_i[i] & ~seen[i];
    if (i < N - 1) begin : g_chain
      assign seen[i+1] = seen[i] | req_i[i];
    end
  end
endmodule

// File: rtl/rst_cause_upd.sv
module rst_cause_upd
  import rst_cause_pkg::*;
(
  input  ev_e        ev_i,
  input  logic [1:0] pmode_i,
  input  logic       stk_full_i,
  input  logic       stk_unf_i,
  input  logic       stk_rst_en_i,
  input  logic       gie_hi_i,
  input  logic       gie_lo_i,
  input  logic       brn_init_i,
  output upd_t       upd_o
);
  logic low_pwr;
  assign low_pwr = pmode_i[1];

  always_comb begin
    upd_o = '{mask: '0, val: '0, restart: 1'b0, wake: 1'b0, pc_sel: PC_HOLD};
    unique case (ev_i)
      EV_PON: begin
        upd_o.mask           = '1;
        upd_o.val[F_INST]    = 1'b1;
        upd_o.val[F_WDT]     = 1'b1;
        upd_o.val[F_PDN]     = 1'b1;
        upd_o.val[F_BRN]     = brn_init_i;
        upd_o.restart        = 1'b1;
        upd_o.pc_sel         = PC_RST;
      end
      EV_BRN: begin
        upd_o.mask[F_INST]   = 1'b1;
        upd_o.mask[F_WDT]    = 1'b1;
        upd_o.mask[F_PDN]    = 1'b1;
        upd_o.mask[F_BRN]    = 1'b1;
        upd_o.val[F_INST]    = 1'b1;
        upd_o.val[F_WDT]     = 1'b1;
        upd_o.val[F_PDN]     = 1'b1;
        upd_o.restart        = 1'b1;
        upd_o.pc_sel         = PC_RST;
      end
      EV_MCLR: begin
        if (pmode_i != PM_FULL) begin
          upd_o.mask[F_WDT]  = 1'b1;
          upd_o.val[F_WDT]   = 1'b1;
        end
        if (low_pwr) upd_o.mask[F_PDN] = 1'b1;
        upd_o.restart        = 1'b1;
        upd_o.pc_sel         = PC_RST;
      end
      EV_WDT: begin
        upd_o.mask[F_WDT]    = 1'b1;
        if (low_pwr) begin
          upd_o.mask[F_PDN]  = 1'b1;
          upd_o.wake         = 1'b1;
          upd_o.pc_sel       = PC_NEXT;
        end else begin
          upd_o.restart      = 1'b1;
          upd_o.pc_sel       = PC_RST;
        end
      end
      EV_STK: begin
        upd_o.mask[F_OVF]    = stk_full_i & stk_rst_en_i;
        upd_o.mask[F_UDF]    = stk_unf_i;
        upd_o.val[F_OVF]     = 1'b1;
        upd_o.val[F_UDF]     = 1'b1;
        upd_o.restart        = stk_rst_en_i;
        upd_o.pc_sel         = stk_rst_en_i ? PC_RST : PC_HOLD;
      end
      EV_INST: begin
        upd_o.mask[F_INST]   = 1'b1;
        upd_o.restart        = 1'b1;
        upd_o.pc_sel         = PC_RST;
      end
      EV_IRQ: begin
        upd_o.mask[F_PDN]    = 1'b1;
        upd_o.wake           = 1'b1;
        upd_o.pc_sel         = gie_hi_i ? PC_HI : (gie_lo_i ? PC_LO : PC_NEXT);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker
  import rst_cause_pkg::*;
#(
  parameter int               PC_W      = 21,
  parameter int               INSTR_B   = 2,
  parameter logic [PC_W-1:0]  RST_VEC   = '0,
  parameter logic [PC_W-1:0]  HI_VEC    = 21'h000008,
  parameter logic [PC_W-1:0]  LO_VEC    = 21'h000018
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             bor_i,
  input  logic             swrst_i,
  input  logic             mclr_i,
  input  logic             wdt_i,
  input  logic             stk_full_i,
  input  logic             stk_unf_i,
  input  logic             irq_wake_i,
  input  logic [1:0]       pmode_i,
  input  logic             stk_rst_en_i,
  input  logic             gie_hi_i,
  input  logic             gie_lo_i,
  input  logic [1:0]       bor_cfg_i,
  input  logic             bor_sw_en_i,
  input  logic [PC_W-1:0]  cur_pc_i,
  input  logic             sw_we_i,
  input  logic [6:0]       sw_wdata_i,
  output logic [6:0]       flags_o,
  output logic             restart_o,
  output logic             wake_o,
  output logic [PC_W-1:0]  next_pc_o
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSTR_B);

  logic            stk_req;
  logic [NREQ-1:0] req, gnt;
  ev_e             ev;
  upd_t            upd;
  logic            brn_init;
  logic [NFLAG-1:0] base, flags_d;
  logic [PC_W-1:0] pc_d;

  assign stk_req  = (stk_full_i & stk_rst_en_i) | stk_unf_i;
  assign req      = {irq_wake_i, swrst_i, stk_req, wdt_i, mclr_i, bor_i, por_i};
  assign brn_init = (bor_cfg_i == 2'b01) & bor_sw_en_i;

  rst_cause_arb #(.N(NREQ)) u_arb (
    .req_i (req),
    .gnt_o (gnt)
  );

  always_comb begin
    ev = EV_NONE;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (gnt[i]) ev = ev_e'(3'(i + 1));
    end
  end

  rst_cause_upd u_upd (
    .ev_i         (ev),
    .pmode_i      (pmode_i),
    .stk_full_i   (stk_full_i),
    .stk_unf_i    (stk_unf_i),
    .stk_rst_en_i (stk_rst_en_i),
    .gie_hi_i     (gie_hi_i),
    .gie_lo_i     (gie_lo_i),
    .brn_init_i   (brn_init),
    .upd_o        (upd)
  );

  // event wins over software write on touched bits
  assign base    = sw_we_i ? sw_wdata_i : flags_o;
  assign flags_d = (base & ~upd.mask) | (upd.val & upd.mask);

  always_comb begin
    unique case (upd.pc_sel)
      PC_RST:  pc_d = RST_VEC;
      PC_NEXT: pc_d = cur_pc_i + PC_STEP;
      PC_HI:   pc_d = HI_VEC;
      PC_LO:   pc_d = LO_VEC;
      default: pc_d = next_pc_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o   <= RST_FLAGS;
      restart_o <= 1'b0;
      wake_o    <= 1'b0;
      next_pc_o <= RST_VEC;
    end else begin
      flags_o   <= flags_d;
      restart_o <= upd.restart;
      wake_o    <= upd.wake;
      next_pc_o <= pc_d;
    end
  end

  logic any_ev;
  assign any_ev = |req;

  // R11
  excl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restart_o && wake_o));

  // R2
  pon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> restart_o && !flags_o[F_PON] && !flags_o[F_OVF] && !flags_o[F_UDF]
              && flags_o[F_INST] && next_pc_o == RST_VEC);

  // R4
  inst_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swrst_i && !por_i && !bor_i && !mclr_i && !wdt_i && !stk_req && !sw_we_i)
    |=> !flags_o[F_INST] && flags_o[6:1] == $past(flags_o[6:1]) && restart_o);

  // R6
  wdt_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_i && pmode_i[1] && !por_i && !bor_i && !mclr_i)
    |=> wake_o && !restart_o && !flags_o[F_WDT] && !flags_o[F_PDN]);

  // R8
  irq_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_wake_i && gie_hi_i && !(por_i || bor_i || mclr_i || wdt_i || stk_req || swrst_i))
    |=> wake_o && next_pc_o == HI_VEC && !flags_o[F_PDN]);

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_ev && !sw_we_i) |=> $stable(flags_o) && $stable(next_pc_o) && !restart_o && !wake_o);

  // R1
  restart_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> next_pc_o == RST_VEC);
endmodule

// File: tb/tb_rst_cause_tracker.sv
module tb_rst_cause_tracker;
  localparam int PC_W = 21;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic por, bor, swrst, mclr, wdt, sful, sunf, irq;
  logic [1:0] pmode = '0;
  logic stk_en = 1'b0, ghi = 1'b0, glo = 1'b0, bsw = 1'b0;
  logic [1:0] bcfg = '0;
  logic [PC_W-1:0] cpc = '0;
  logic we = 1'b0;
  logic [6:0] wd = '0;
  logic [6:0] flags;
  logic restart, wake;
  logic [PC_W-1:0] npc;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [6:0] m_flags = 7'b0000111;
  logic [PC_W-1:0] m_pc = '0;
  logic m_rst = 1'b0, m_wake = 1'b0;

  always #10 clk = ~clk;

  initial begin
    {por, bor, swrst, mclr, wdt, sful, sunf, irq} = '0;
  end

  rst_cause_tracker #(.PC_W(PC_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por), .bor_i(bor), .swrst_i(swrst),
    .mclr_i(mclr), .wdt_i(wdt), .stk_full_i(sful), .stk_unf_i(sunf),
    .irq_wake_i(irq), .pmode_i(pmode), .stk_rst_en_i(stk_en), .gie_hi_i(ghi),
    .gie_lo_i(glo), .bor_cfg_i(bcfg), .bor_sw_en_i(bsw), .cur_pc_i(cpc),
    .sw_we_i(we), .sw_wdata_i(wd), .flags_o(flags), .restart_o(restart),
    .wake_o(wake), .next_pc_o(npc)
  );

  task automatic compare(input string tag);
    checks++;
    if (flags !== m_flags || restart !== m_rst || wake !== m_wake || npc !== m_pc) begin
      errors++;
      $display("FAIL %s: flags=%b rst=%b wake=%b pc=%h exp flags=%b rst=%b wake=%b pc=%h",
               tag, flags, restart, wake, npc, m_flags, m_rst, m_wake, m_pc);
    end
  endtask

  // reference update built from the requirement text
  function automatic string model();
    logic [6:0] f;
    logic sreq;
    int n;
    string tag;
    f = we ? wd : m_flags;
    sreq = (sful & stk_en) | sunf;
    n = int'(por) + int'(bor) + int'(mclr) + int'(wdt) + int'(sreq) + int'(swrst) + int'(irq);
    m_rst = 1'b0; m_wake = 1'b0;
    tag = we ? "R10" : "R11";
    if (por) begin                                   // R2
      f = {1'b0, 1'b0, ((bcfg == 2'b01) && bsw), 1'b0, 3'b111};
      m_rst = 1'b1; m_pc = '0; tag = "R2";
    end else if (bor) begin                          // R3
      f[4] = 1'b0; f[2:0] = 3'b111;
      m_rst = 1'b1; m_pc = '0; tag = "R3";
    end else if (mclr) begin                         // R5
      if (pmode != 2'd0) f[1] = 1'b1;
      if (pmode[1]) f[2] = 1'b0;
      m_rst = 1'b1; m_pc = '0; tag = "R5";
    end else if (wdt) begin                          // R6
      f[1] = 1'b0;
      if (pmode[1]) begin
        f[2] = 1'b0; m_wake = 1'b1; m_pc = cpc + 2;
      end else begin
        m_rst = 1'b1; m_pc = '0;
      end
      tag = "R6";
    end else if (sreq) begin                         // R7
      if (sful && stk_en) f[5] = 1'b1;
      if (sunf) f[6] = 1'b1;
      if (stk_en) begin m_rst = 1'b1; m_pc = '0; end
      tag = "R7";
    end else if (swrst) begin                        // R4
      f[0] = 1'b0; m_rst = 1'b1; m_pc = '0; tag = "R4";
    end else if (irq) begin                          // R8
      f[2] = 1'b0; m_wake = 1'b1;
      m_pc = ghi ? 21'h8 : (glo ? 21'h18 : cpc + 2);
      tag = "R8";
    end
    if (n > 1) tag = {tag, "/R9"};
    if (we && n > 0) tag = {tag, "/R10"};
    m_flags = f;
    return tag;
  endfunction

  task automatic step(input logic [7:0] ev, input logic [1:0] pm, input logic en,
                      input logic hi, input logic lo, input logic w, input logic [6:0] d,
                      input string force_tag = "");
    string tag;
    {irq, sunf, sful, wdt, mclr, swrst, bor, por} = ev;
    pmode = pm; stk_en = en; ghi = hi; glo = lo; we = w; wd = d;
    cpc = PC_W'($urandom) & ~PC_W'(1);
    tag = model();
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    compare(tag);
  endtask

  // event bit order: [0]por [1]bor [2]swrst [3]mclr [4]wdt [5]full [6]unf [7]irq
  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    step(8'h00, 0, 0, 0, 0, 0, 0, "R1");
    // R2 brown-out initial value
    bcfg = 2'b01; bsw = 1'b1;
    step(8'h01, 0, 0, 0, 0, 0, 0);
    bcfg = 2'b11;
    step(8'h01, 0, 0, 0, 0, 0, 0);
    bcfg = 2'b01; bsw = 1'b0;
    step(8'h01, 0, 0, 0, 0, 0, 0);
    // R10 write, then write overridden by reset instruction
    step(8'h00, 0, 0, 0, 0, 1, 7'h7f);
    step(8'h04, 0, 0, 0, 0, 1, 7'h7f);
    // R3
    step(8'h00, 0, 0, 0, 0, 1, 7'h78);
    step(8'h02, 0, 0, 0, 0, 0, 0);
    // R5 each mode
    for (int m = 0; m < 4; m++) begin
      step(8'h00, 0, 0, 0, 0, 1, 7'h05);
      step(8'h08, 2'(m), 0, 0, 0, 0, 0);
    end
    // R6 run vs sleep vs idle
    step(8'h00, 0, 0, 0, 0, 1, 7'h07);
    step(8'h10, 1, 0, 0, 0, 0, 0);
    step(8'h00, 0, 0, 0, 0, 1, 7'h07);
    step(8'h10, 3, 0, 0, 0, 0, 0);
    step(8'h10, 2, 0, 0, 0, 0, 0);
    // R7 enabled / disabled
    step(8'h00, 0, 0, 0, 0, 1, 7'h00);
    step(8'h20, 0, 1, 0, 0, 0, 0);
    step(8'h40, 0, 1, 0, 0, 0, 0);
    step(8'h00, 0, 0, 0, 0, 1, 7'h00);
    step(8'h20, 0, 0, 0, 0, 0, 0, "R7");
    step(8'h40, 0, 0, 0, 0, 0, 0);
    step(8'h60, 0, 0, 0, 0, 0, 0);
    // R8 vectors
    step(8'h80, 2, 0, 1, 1, 0, 0);
    step(8'h80, 3, 0, 0, 1, 0, 0);
    step(8'h80, 2, 0, 0, 0, 0, 0);
    // R9 collisions
    step(8'h81, 0, 0, 0, 0, 0, 0);
    step(8'h18, 3, 0, 0, 0, 0, 0);
    step(8'h64, 0, 1, 0, 0, 0, 0);
    step(8'h84, 2, 0, 1, 0, 0, 0);
    step(8'h92, 0, 0, 0, 0, 1, 7'h7f);
    // R11 pulses drop and state holds
    step(8'h00, 1, 1, 1, 1, 0, 0);
    step(8'h00, 2, 0, 0, 0, 0, 0);
    // random phase
    for (int k = 0; k < 400; k++) begin
      logic [7:0] e;
      e = '0;
      for (int b = 0; b < 8; b++) e[b] = ($urandom % 14) == 0;
      step(e, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 8) == 0, 7'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule